// File: doc/BRIEF.md
# Framed Timestamp Serial Receiver

This block listens to a single synchronization line and recovers a 64-bit message that the sender clocks out at a fixed bit rate, with no separate clock. A message begins with a fixed 6-bit opening pattern and ends with a fixed 6-bit closing pattern. Between them sit 52 payload bits: a 32-bit seconds count followed by a 20-bit microseconds count.

The receiver starts a message when the line rises while it is idle. It then ignores further edges until all 64 bits have been sampled. The first sample is taken about three quarters of a bit cell after the start, and every later sample is taken one full bit length after the one before. The bit length in clock cycles is a runtime input.

When both patterns match, the block announces the timestamp with a one-cycle pre-strobe and then puts it on a byte bus over eight cycles. When either pattern is wrong, the message is dropped and a one-cycle error pulse is given instead.

Top module: `ts_serial_rx`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), pre_stb and frame_err are 0 and data is 8'h00.
- R2: For a good message, pre_stb is high for exactly one cycle. In the eight following cycles, data carries seconds bits [7:0], [15:8], [23:16] and [31:24], then microseconds bits [7:0], [15:8], then {4'b0, usec[19:16]}, then 8'h00. Outside those eight cycles data is 8'h00.
- R3: Line bits are taken MSB first in this order: opening pattern 6'b110100 (leftmost bit sent first), seconds[31:0], microseconds[19:0], closing pattern 6'b001101 (leftmost bit sent first).
- R4: If the first six received bits differ from 6'b110100, no pre_stb occurs, data stays 8'h00, and frame_err is high for exactly one cycle.
- R5: If the last six received bits differ from 6'b001101, no pre_stb occurs, data stays 8'h00, and frame_err is high for exactly one cycle.
- R6: A message starts on any 0-to-1 transition of line_in while the receiver is idle. A line held at 0 produces neither a strobe nor an error. A lone one-cycle high pulse starts a reception that ends in one frame_err.
- R7: While a message is being received, transitions on line_in start nothing new. Only the sampled values enter the message.
- R8: After the 64th sample the receiver rearms, so a second message that follows shortly after is also received.
- R9: The bit length bit_len (clock cycles per bit, at least 8) sets the sampling rate. Messages sent with 8, 16 and 20 cycles per bit are received when bit_len matches.
- R10: The first sample is taken floor(3*bit_len/4) cycles after the start is detected, and each later sample one bit_len after the previous one. A value that is valid only during the last 3/8 of each bit cell is still received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Serial synchronization line, idle low |
| bit_len | input | 8 | Clock cycles per bit cell |
| pre_stb | output | 1 | One-cycle pulse one clock before the first byte |
| data | output | 8 | Timestamp byte stream, zero when not streaming |
| frame_err | output | 1 | One-cycle pulse when a framing pattern mismatches |

## Verification
A wrong bit counter or sample timer does not hang the block silently. It shows as a missing or shifted message: one 64-bit message later, either frame_err pulses or the bytes come out rotated. A deaf window that is too short shows as a spurious error after a message whose payload has rising edges. Sampling too early is caught by messages whose cells hold the wrong value for their first 5/8. A serializer fault shows within nine cycles of pre_stb, as a wrong byte order or a nonzero top byte.

// File: rtl/ts_rx_pkg.sv
// Shared constants and types for the framed timestamp receiver.
package ts_rx_pkg;
    localparam int           MAGIC_W     = 6;
    localparam logic [5:0]   LEAD_MAGIC  = 6'b110100;
    localparam logic [5:0]   TRAIL_MAGIC = 6'b001101;
    localparam int           SEC_W       = 32;
    localparam int           USEC_W      = 20;
    localparam int           PAYLOAD_W   = SEC_W + USEC_W;
    localparam int           MSG_BITS    = 2 * MAGIC_W + PAYLOAD_W;
    localparam int           BYTE_W      = 8;
    localparam int           OUT_BYTES   = 8;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [USEC_W-1:0] usec;
    } ts_payload_t;
endpackage

// File: rtl/ts_rx_edge.sv
// Line register and rising-edge detector.
// Assumes line_in is already synchronous to clk; a start is flagged only while idle.
module ts_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic idle,
    output logic line_s,
    output logic start
);
    logic line_p;

    // Register the line and keep the previous value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_s <= 1'b0;
            line_p <= 1'b0;
        end else begin
            line_s <= line_in;
            line_p <= line_s;
        end
    end

    assign start = idle && line_s && !line_p;
endmodule

// File: rtl/ts_rx_sampler.sv
// Bit timer and shift register. It takes the first sample floor(3L/4) cycles
// after start and then one sample every L cycles, collecting MSG_BITS bits MSB first.
// Assumes bit_len >= 8. It ignores start while busy (deaf window).
module ts_rx_sampler #(
    parameter int LEN_W    = 8,
    parameter int MSG_BITS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                line_s,
    input  logic [LEN_W-1:0]    bit_len,
    output logic                busy,
    output logic                done,
    output logic [MSG_BITS-1:0] msg
);
    localparam int IDX_W = $clog2(MSG_BITS);

    logic [LEN_W+1:0] len_x3;
    logic [LEN_W-1:0] short_len;
    logic [LEN_W-1:0] cnt;
    logic [IDX_W-1:0] idx;

    assign len_x3    = {2'b00, bit_len} + {1'b0, bit_len, 1'b0};
    assign short_len = LEN_W'(len_x3 >> 2) - LEN_W'(1);

    // Count down to each sampling point and shift the sampled bit in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            idx  <= '0;
            msg  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    cnt  <= short_len;
                    idx  <= '0;
                end
            end else if (cnt == '0) begin
                msg <= {msg[MSG_BITS-2:0], line_s};
                cnt <= bit_len - LEN_W'(1);
                if (idx == IDX_W'(MSG_BITS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end else begin
                cnt <= cnt - LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/ts_rx_serializer.sv
// Byte serializer. On load it raises pre_stb for one cycle and then puts
// OUT_BYTES bytes on data, low byte first: seconds, then microseconds zero-extended.
// Assumes SEC_W is a multiple of BYTE_W and the payload fits OUT_BYTES bytes.
module ts_rx_serializer #(
    parameter int SEC_W     = 32,
    parameter int USEC_W    = 20,
    parameter int BYTE_W    = 8,
    parameter int OUT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SEC_W-1:0]  sec,
    input  logic [USEC_W-1:0] usec,
    output logic              pre_stb,
    output logic [BYTE_W-1:0] data
);
    localparam int WORD_W = OUT_BYTES * BYTE_W;
    localparam int CNT_W  = $clog2(OUT_BYTES + 1);

    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  left;

    // Load the word on a good frame, then shift one byte out per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_stb <= 1'b0;
            data    <= '0;
            word    <= '0;
            left    <= '0;
        end else begin
            pre_stb <= load;
            if (load) begin
                word <= WORD_W'({usec, sec});
                left <= CNT_W'(OUT_BYTES);
                data <= '0;
            end else if (left != '0) begin
                data <= word[BYTE_W-1:0];
                word <= word >> BYTE_W;
                left <= left - CNT_W'(1);
            end else begin
                data <= '0;
            end
        end
    end
endmodule

// File: rtl/ts_serial_rx.sv
// Framed timestamp serial receiver. It receives a 64-bit self-clocked message,
// checks the opening and closing patterns, and streams the seconds/microseconds
// payload as bytes. Assumes line_in is synchronous to clk and idles low.
module ts_serial_rx
    import ts_rx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic [LEN_W-1:0]  bit_len,
    output logic              pre_stb,
    output logic [BYTE_W-1:0] data,
    output logic              frame_err
);
    logic                line_s;
    logic                start;
    logic                busy;
    logic                done;
    logic [MSG_BITS-1:0] msg;
    logic                lead_ok;
    logic                trail_ok;
    logic                good;
    ts_payload_t         pay;

    ts_rx_edge i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .idle    (!busy),
        .line_s  (line_s),
        .start   (start)
    );

    ts_rx_sampler #(
        .LEN_W    (LEN_W),
        .MSG_BITS (MSG_BITS)
    ) i_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .line_s  (line_s),
        .bit_len (bit_len),
        .busy    (busy),
        .done    (done),
        .msg     (msg)
    );

    assign lead_ok  = msg[MSG_BITS-1 -: MAGIC_W] == LEAD_MAGIC;
    assign trail_ok = msg[MAGIC_W-1:0] == TRAIL_MAGIC;
    assign pay      = msg[MAGIC_W +: PAYLOAD_W];
    assign good     = done && lead_ok && trail_ok;

    // Pulse the error flag once for a message with a bad pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_err <= 1'b0;
        else        frame_err <= done && !(lead_ok && trail_ok);
    end

    ts_rx_serializer #(
        .SEC_W     (SEC_W),
        .USEC_W    (USEC_W),
        .BYTE_W    (BYTE_W),
        .OUT_BYTES (OUT_BYTES)
    ) i_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (good),
        .sec     (pay.sec),
        .usec    (pay.usec),
        .pre_stb (pre_stb),
        .data    (data)
    );
endmodule

// File: rtl/ts_serial_rx_chk.sv
// Port-level checker for ts_serial_rx. It tracks the byte window after pre_stb.
module ts_serial_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pre_stb,
    input logic       frame_err,
    input logic [7:0] data
);
    logic [3:0] win;

    // Count the eight byte cycles that follow a pre-strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           win <= '0;
        else if (pre_stb)     win <= 4'd8;
        else if (win != '0)   win <= win - 4'd1;
    end

    // R2
    pre_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_stb |=> !pre_stb);
    // R2
    data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win == 4'd0) |-> (data == 8'h00));
    // R2
    top_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win == 4'd1) |-> (data == 8'h00));
    // R4
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);
    // R5
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (!pre_stb && win == 4'd0));
    // R8
    no_restrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_stb |-> (win == 4'd0));
endmodule

bind ts_serial_rx ts_serial_rx_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_stb   (pre_stb),
    .frame_err (frame_err),
    .data      (data)
);

// File: tb/test_ts_serial_rx.sv
module test_ts_serial_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic [7:0] bit_len = 8'd16;
    logic       pre_stb;
    logic [7:0] data;
    logic       frame_err;

    int compared = 0;
    int mismatched = 0;
    int frames = 0;
    int errs = 0;
    int cap_left = 0;
    logic [7:0] cap [8];

    always #4 clk = ~clk;

    ts_serial_rx i_ts_serial_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .bit_len   (bit_len),
        .pre_stb   (pre_stb),
        .data      (data),
        .frame_err (frame_err)
    );

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cap_left > 0) begin
                cap[8 - cap_left] = data;
                cap_left = cap_left - 1;
                if (cap_left == 0) frames = frames + 1;
            end
            if (pre_stb) cap_left = 8;
            if (frame_err) errs = errs + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [5:0] lead, input logic [31:0] s,
                                       input logic [19:0] u, input logic [5:0] trail);
        return {lead, s, u, trail};
    endfunction

    // Drive one message; with gp > 0 each cell after the first holds the inverse for gp cycles.
    task automatic send(input logic [63:0] m, input int len, input int gp);
        for (int k = 0; k < 64; k++) begin
            for (int c = 0; c < len; c++) begin
                line_in = (k > 0 && c < gp) ? ~m[63-k] : m[63-k];
                @(negedge clk);
            end
        end
        line_in = 1'b0;
    endtask

    task automatic check_bytes(input string req, input logic [31:0] s, input logic [19:0] u);
        logic [63:0] w;
        w = {12'h000, u, s};
        for (int i = 0; i < 8; i++)
            chk(cap[i] == w[8*i +: 8], req, {56'h0, cap[i]}, {56'h0, w[8*i +: 8]});
    endtask

    task automatic good_frame(input string req, input int len, input int gp,
                              input logic [31:0] s, input logic [19:0] u);
        int f0, e0;
        f0 = frames; e0 = errs;
        bit_len = 8'(len);
        send(mk(6'b110100, s, u, 6'b001101), len, gp);
        repeat (20) @(negedge clk);
        chk(frames == f0 + 1, req, 64'(frames - f0), 64'd1);
        chk(errs == e0, req, 64'(errs - e0), 64'd0);
        check_bytes(req, s, u);
    endtask

    task automatic bad_frame(input string req, input logic [63:0] m);
        int f0, e0;
        f0 = frames; e0 = errs;
        bit_len = 8'd16;
        send(m, 16, 0);
        repeat (20) @(negedge clk);
        chk(frames == f0, req, 64'(frames - f0), 64'd0);
        chk(errs == e0 + 1, req, 64'(errs - e0), 64'd1);
        chk(data == 8'h00, req, {56'h0, data}, 64'h0);
    endtask

    task automatic t_reset();
        // R1
        chk(pre_stb == 1'b0, "R1", {63'h0, pre_stb}, 64'h0);
        chk(frame_err == 1'b0, "R1", {63'h0, frame_err}, 64'h0);
        chk(data == 8'h00, "R1", {56'h0, data}, 64'h0);
    endtask

    task automatic t_idle_and_glitch();
        int f0, e0;
        f0 = frames; e0 = errs;
        line_in = 1'b0;
        repeat (300) @(negedge clk);
        chk(frames == f0 && errs == e0, "R6 idle", 64'(errs - e0), 64'd0);
        bit_len = 8'd8;
        line_in = 1'b1;
        @(negedge clk);
        line_in = 1'b0;
        repeat (64 * 8 + 20) @(negedge clk);
        chk(errs == e0 + 1, "R6 glitch", 64'(errs - e0), 64'd1);
        chk(frames == f0, "R6 glitch", 64'(frames - f0), 64'd0);
    endtask

    task automatic t_back_to_back();
        int f0;
        f0 = frames;
        bit_len = 8'd16;
        send(mk(6'b110100, 32'hCAFE_0001, 20'h12345, 6'b001101), 16, 0);
        repeat (12) @(negedge clk);
        chk(frames == f0 + 1, "R8 first", 64'(frames - f0), 64'd1);
        check_bytes("R8 first", 32'hCAFE_0001, 20'h12345);
        send(mk(6'b110100, 32'h0BAD_F00D, 20'h54321, 6'b001101), 16, 0);
        repeat (20) @(negedge clk);
        chk(frames == f0 + 2, "R8 second", 64'(frames - f0), 64'd2);
        check_bytes("R8 second", 32'h0BAD_F00D, 20'h54321);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        // R2 R3 basic message
        good_frame("R2 R3 basic", 16, 0, 32'h1234_5678, 20'hABCDE);
        // R9 shortest and longer bit lengths
        good_frame("R9 len8", 8, 0, 32'hDEAD_BEEF, 20'h00001);
        good_frame("R9 len20", 20, 0, 32'h8000_0001, 20'hFFFFF);
        // R10 R7 late sampling point with edges inside each cell
        good_frame("R10 R7 phase", 16, 10, 32'hA5A5_5A5A, 20'h5A5A5);
        // R4 bad opening pattern
        bad_frame("R4", mk(6'b110101, 32'h1111_2222, 20'h33333, 6'b001101));
        // R5 bad closing pattern
        bad_frame("R5", mk(6'b110100, 32'h1111_2222, 20'h33333, 6'b001100));
        t_idle_and_glitch();
        t_back_to_back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule